// File: doc/BRIEF.md
# UART Register File with Prioritised Interrupts

This block is the register set of a 16550-style serial port. A host reaches it through a 32-bit word-addressed register port. A separate serial engine sits on its other side and exchanges whole bytes with it over a receive handshake and a transmit handshake. The block holds one received byte, one byte waiting to be sent, the line status flags, the interrupt enables, the line control and modem control settings and a baud divisor. It drives the line control, modem control and divisor settings out to the engine.

The block raises a single level interrupt and reports its cause through an identification register. Four causes are ranked in a fixed order: receive line errors first, then received data, then transmit holding empty, then modem status changes. The interrupt line and the identification code follow the register contents in the same cycle.

Modem status arrives as plain input bits and is presented unchanged. Serialisation, FIFOs, parity generation and pin sampling belong to the engine.

Top module: `uart_regfile`

## Requirements
- R1: After reset every register reads zero, except line status, which reads 0x60 (transmit holding empty and transmitter empty set), and identification, which reads 0x01. The irq output is low, rx_ready is high, tx_valid is low, and line_ctrl, modem_ctrl and baud_div are zero.
- R2: Byte address bits [4:2] select the register, and bits [1:0] are ignored. The codes are: 0 data, 1 interrupt enable, 2 identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 divisor.
- R3: Interrupt enable, line control, modem control and divisor are write-only and read back as zero. A write to line control, modem control or divisor appears on line_ctrl, modem_ctrl or baud_div, taking the low 8, 8 or DIV_W bits of the write data.
- R4: Writes to identification, line status and modem status have no effect on any register or output.
- R5: rx_ready is high exactly when data ready (line status bit 0) is clear. An rx_valid pulse stores rx_byte and sets data ready. A read of the data register returns the held byte in bits [7:0] and clears data ready.
- R6: A byte that arrives while data ready is set sets overrun (line status bit 1), replaces the held byte and leaves data ready set. If this happens in the same cycle as a data read, the read returns the old byte and the new byte's arrival takes effect.
- R7: The rx_parity_err, rx_frame_err and rx_break inputs are captured with the byte into line status bits 2, 3 and 4. Bits 1 to 4 stay set until line status is read. That read returns them and then clears them. A flag set in the same cycle as the read survives.
- R8: Writing the data register places the low 8 bits on tx_byte, raises tx_valid and clears line status bits 5 and 6. A cycle with tx_valid and tx_ready both high sets bit 5. Bit 6 sets in the cycle after bit 5 is set while tx_idle is high, and it clears while tx_idle is low.
- R9: Interrupt enable bits: bit 0 received data, bit 1 transmit holding empty, bit 2 receive line status, bit 3 modem status.
- R10: Identification bits [2:0], highest priority first: any of line status bits 1 to 4 with enable bit 2 gives 3'b110. Data ready with enable bit 0 gives 3'b100. Holding empty with enable bit 1 gives 3'b010. Any of modem_status[3:0] with enable bit 3 gives 3'b000. With no cause the code is 3'b001.
- R11: irq is high exactly when the identification code is not 3'b001. It follows register and input changes without an added cycle of delay.
- R12: The modem status register reads back modem_status[7:0] unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address; bits [4:2] pick the register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe (applies read side effects at the clock edge) |
| reg_rdata | output | DATA_W | Read data for the addressed register, combinational |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Engine presents a received byte |
| rx_byte | input | 8 | Received byte |
| rx_parity_err | input | 1 | Parity error flag for the byte |
| rx_frame_err | input | 1 | Framing error flag for the byte |
| rx_break | input | 1 | Break flag for the byte |
| rx_ready | output | 1 | Block can take a byte without overrun |
| tx_valid | output | 1 | A byte is waiting for the engine |
| tx_byte | output | 8 | Byte to send |
| tx_ready | input | 1 | Engine takes the waiting byte |
| tx_idle | input | 1 | Engine shift stage is empty |
| modem_status | input | 8 | Modem status bits from pin logic |
| line_ctrl | output | 8 | Line control setting |
| modem_ctrl | output | 8 | Modem control setting |
| baud_div | output | DIV_W | Baud divisor |

## Verification
Two pairs of functions can collide in one cycle: a host read of the data register against an arriving byte, and a host read of line status against an arriving byte that carries a new error flag. The bench provokes each pair by raising the read strobe and rx_valid together. It then checks that the read returns the old contents, that the arrival's effects (data ready, overrun, the new error bit) are present afterwards, and that flags from before the read are gone. The prioritised interrupt is swept over every enable pattern against every combination of the four causes, and the bench compares irq and the identification value with a priority function of its own.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  typedef enum logic [2:0] {
    REG_DATA  = 3'd0,
    REG_IEN   = 3'd1,
    REG_IID   = 3'd2,
    REG_LCTL  = 3'd3,
    REG_MCTL  = 3'd4,
    REG_LSTAT = 3'd5,
    REG_MSTAT = 3'd6,
    REG_DIV   = 3'd7
  } regSel_e;

  localparam logic [2:0] IID_LINE  = 3'b110;
  localparam logic [2:0] IID_RXD   = 3'b100;
  localparam logic [2:0] IID_THR   = 3'b010;
  localparam logic [2:0] IID_MODEM = 3'b000;
  localparam logic [2:0] IID_NONE  = 3'b001;

  // interrupt enable bit positions
  localparam int IEN_RXD   = 0;
  localparam int IEN_THR   = 1;
  localparam int IEN_LINE  = 2;
  localparam int IEN_MODEM = 3;
  localparam int IEN_W     = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic    wrTx;
    logic    wrIen;
    logic    wrLctl;
    logic    wrMctl;
    logic    wrDiv;
    logic    rdRx;
    logic    rdLstat;
    regSel_e sel;
  } regStrobe_t;

endpackage

// File: rtl/uart_regs_ctrl.sv
module uart_regs_ctrl
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output regStrobe_t        strobe
);

  localparam int SEL_LSB = 2;
  localparam int SEL_W   = 3;

  regSel_e sel;
  logic    unusedAddr;

  assign sel        = regSel_e'(addr[SEL_LSB +: SEL_W]);
  assign unusedAddr = &{1'b0, addr[SEL_LSB-1:0]};

  always_comb begin
    strobe     = '0;
    strobe.sel = sel;
    if (wrEn) begin
      unique case (sel)
        REG_DATA: strobe.wrTx   = 1'b1;
        REG_IEN:  strobe.wrIen  = 1'b1;
        REG_LCTL: strobe.wrLctl = 1'b1;
        REG_MCTL: strobe.wrMctl = 1'b1;
        REG_DIV:  strobe.wrDiv  = 1'b1;
        default:  ;
      endcase
    end
    if (rdEn) begin
      unique case (sel)
        REG_DATA:  strobe.rdRx    = 1'b1;
        REG_LSTAT: strobe.rdLstat = 1'b1;
        default:   ;
      endcase
    end
  end

  // R2: at most one write strobe per access
  a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.wrTx, strobe.wrIen, strobe.wrLctl, strobe.wrMctl, strobe.wrDiv}));

  // R4: read-only registers never produce a write strobe
  a_r4_ro_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && (sel == REG_IID || sel == REG_LSTAT || sel == REG_MSTAT)) |->
      !(strobe.wrTx || strobe.wrIen || strobe.wrLctl || strobe.wrMctl || strobe.wrDiv));

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_regs_pkg::*;
#(
  parameter int DELTA_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IEN_W-1:0]   ien,
  input  logic               lineErr,
  input  logic               dataReady,
  input  logic               thrEmpty,
  input  logic [DELTA_W-1:0] modemDelta,
  output logic [2:0]         iid,
  output logic               irqOut
);

  logic causeLine, causeRxd, causeThr, causeModem;

  assign causeLine  = lineErr    && ien[IEN_LINE];
  assign causeRxd   = dataReady  && ien[IEN_RXD];
  assign causeThr   = thrEmpty   && ien[IEN_THR];
  assign causeModem = (|modemDelta) && ien[IEN_MODEM];

  always_comb begin
    if (causeLine)       iid = IID_LINE;
    else if (causeRxd)   iid = IID_RXD;
    else if (causeThr)   iid = IID_THR;
    else if (causeModem) iid = IID_MODEM;
    else                 iid = IID_NONE;
  end

  assign irqOut = causeLine | causeRxd | causeThr | causeModem;

  // R10: line errors outrank everything
  a_r10_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (lineErr && ien[IEN_LINE]) |-> (iid == IID_LINE));

  // R10: received data outranks transmit and modem
  a_r10_rxd_over_thr: assert property (@(posedge clk) disable iff (!rst_n)
    (!lineErr && dataReady && ien[IEN_RXD]) |-> (iid == IID_RXD));

  // R11: irq low means identification shows no cause
  a_r11_quiet_code: assert property (@(posedge clk) disable iff (!rst_n)
    !irqOut |-> (iid == IID_NONE));

endmodule

// File: rtl/uart_regs_dp.sv
module uart_regs_dp
  import uart_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8,
  parameter int CTL_W  = 8,
  parameter int MSR_W  = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        iid,
  output logic [DATA_W-1:0] rdData,
  // receive side
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxByte,
  input  logic              rxParity,
  input  logic              rxFrame,
  input  logic              rxBreak,
  output logic              rxReady,
  // transmit side
  output logic              txValid,
  output logic [CHAR_W-1:0] txByte,
  input  logic              txReady,
  input  logic              txIdle,
  // modem and settings
  input  logic [MSR_W-1:0]  modemStat,
  output logic [CTL_W-1:0]  lineCtl,
  output logic [CTL_W-1:0]  modemCtl,
  output logic [DIV_W-1:0]  baudDiv,
  // to priority encoder
  output logic [IEN_W-1:0]  ien,
  output logic              lineErr,
  output logic              dataReady,
  output logic              thrEmpty,
  output logic [3:0]        modemDelta
);

  localparam int ERR_N = 4;      // overrun, parity, framing, break
  localparam int LSR_W = 7;

  logic [CHAR_W-1:0] rxHold;
  logic [CHAR_W-1:0] txHold;
  logic              txEmpty;
  logic [ERR_N-1:0]  errBits;
  logic [ERR_N-1:0]  errSet;
  logic [LSR_W-1:0]  lsr;
  logic              unusedWr;

  assign unusedWr = ^wrData;

  // ---------------- receive holding ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxHold    <= '0;
      dataReady <= 1'b0;
    end else if (rxValid) begin
      rxHold    <= rxByte;
      dataReady <= 1'b1;
    end else if (strobe.rdRx) begin
      dataReady <= 1'b0;
    end
  end

  assign rxReady = !dataReady;

  // ---------------- sticky error flags ----------------
  assign errSet = {rxValid & rxBreak, rxValid & rxFrame,
                   rxValid & rxParity, rxValid & dataReady};

  for (genvar i = 0; i < ERR_N; i++) begin : g_err
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              errBits[i] <= 1'b0;
      else if (errSet[i])      errBits[i] <= 1'b1;
      else if (strobe.rdLstat) errBits[i] <= 1'b0;
    end
  end

  assign lineErr = |errBits;

  // ---------------- transmit holding ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txHold   <= '0;
      thrEmpty <= 1'b1;
    end else if (strobe.wrTx) begin
      txHold   <= wrData[CHAR_W-1:0];
      thrEmpty <= 1'b0;
    end else if (txValid && txReady) begin
      thrEmpty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    txEmpty <= 1'b1;
    else if (strobe.wrTx)          txEmpty <= 1'b0;
    else if (thrEmpty && txIdle)   txEmpty <= 1'b1;
    else if (!txIdle)              txEmpty <= 1'b0;
  end

  assign txValid = !thrEmpty;
  assign txByte  = txHold;

  // ---------------- write-only settings ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien      <= '0;
      lineCtl  <= '0;
      modemCtl <= '0;
      baudDiv  <= '0;
    end else begin
      if (strobe.wrIen)  ien      <= wrData[IEN_W-1:0];
      if (strobe.wrLctl) lineCtl  <= wrData[CTL_W-1:0];
      if (strobe.wrMctl) modemCtl <= wrData[CTL_W-1:0];
      if (strobe.wrDiv)  baudDiv  <= wrData[DIV_W-1:0];
    end
  end

  assign modemDelta = modemStat[3:0];

  // ---------------- read mux ----------------
  assign lsr = {txEmpty, thrEmpty, errBits, dataReady};

  always_comb begin
    rdData = '0;
    unique case (strobe.sel)
      REG_DATA:  rdData[CHAR_W-1:0] = rxHold;
      REG_IID:   rdData[2:0]        = iid;
      REG_LSTAT: rdData[LSR_W-1:0]  = lsr;
      REG_MSTAT: rdData[MSR_W-1:0]  = modemStat;
      default:   rdData             = '0;
    endcase
  end

  // R5: data read with no arrival clears data ready
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.rdRx && !rxValid) |=> !dataReady);

  // R6: arrival on a full holding register flags overrun and keeps the new byte
  a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rxValid && dataReady) |=> (errBits[0] && dataReady && rxHold == $past(rxByte)));

  // R7: a parity flag survives until line status is read
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (errBits[1] && !strobe.rdLstat) |=> errBits[1]);

  // R7: a line status read with no arrival leaves all error flags clear
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.rdLstat && !rxValid) |=> (errBits == '0));

  // R8: a data write leaves a byte pending and the transmitter busy
  a_r8_tx_pending: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrTx |=> (txValid && !txEmpty));

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_parity_err,
  input  logic              rx_frame_err,
  input  logic              rx_break,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready,
  input  logic              tx_idle,
  input  logic [7:0]        modem_status,
  output logic [7:0]        line_ctrl,
  output logic [7:0]        modem_ctrl,
  output logic [DIV_W-1:0]  baud_div
);

  regStrobe_t       strobe;
  logic [2:0]       iid;
  logic [IEN_W-1:0] ien;
  logic             lineErr, dataReady, thrEmpty;
  logic [3:0]       modemDelta;

  uart_regs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (reg_addr),
    .wrEn   (reg_wr),
    .rdEn   (reg_rd),
    .strobe (strobe)
  );

  uart_regs_dp #(
    .DATA_W (DATA_W),
    .CHAR_W (8),
    .CTL_W  (8),
    .MSR_W  (8),
    .DIV_W  (DIV_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .wrData     (reg_wdata),
    .iid        (iid),
    .rdData     (reg_rdata),
    .rxValid    (rx_valid),
    .rxByte     (rx_byte),
    .rxParity   (rx_parity_err),
    .rxFrame    (rx_frame_err),
    .rxBreak    (rx_break),
    .rxReady    (rx_ready),
    .txValid    (tx_valid),
    .txByte     (tx_byte),
    .txReady    (tx_ready),
    .txIdle     (tx_idle),
    .modemStat  (modem_status),
    .lineCtl    (line_ctrl),
    .modemCtl   (modem_ctrl),
    .baudDiv    (baud_div),
    .ien        (ien),
    .lineErr    (lineErr),
    .dataReady  (dataReady),
    .thrEmpty   (thrEmpty),
    .modemDelta (modemDelta)
  );

  uart_irq_prio #(.DELTA_W(4)) u_prio (
    .clk        (clk),
    .rst_n      (rst_n),
    .ien        (ien),
    .lineErr    (lineErr),
    .dataReady  (dataReady),
    .thrEmpty   (thrEmpty),
    .modemDelta (modemDelta),
    .iid        (iid),
    .irqOut     (irq)
  );

endmodule

// File: tb/uart_regfile_tb.sv
`timescale 1ns/1ps
module uart_regfile_tb;

  localparam int DIV_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_parity_err = 1'b0;
  logic        rx_frame_err = 1'b0;
  logic        rx_break = 1'b0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        tx_ready = 1'b0;
  logic        tx_idle = 1'b1;
  logic [7:0]  modem_status = '0;
  logic [7:0]  line_ctrl;
  logic [7:0]  modem_ctrl;
  logic [DIV_W-1:0] baud_div;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_regfile #(.ADDR_W(5), .DATA_W(32), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_parity_err(rx_parity_err),
    .rx_frame_err(rx_frame_err), .rx_break(rx_break), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready), .tx_idle(tx_idle),
    .modem_status(modem_status), .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl),
    .baud_div(baud_div)
  );

  localparam logic [4:0] A_DATA = 5'h00, A_IEN = 5'h04, A_IID = 5'h08, A_LCTL = 5'h0C,
                         A_MCTL = 5'h10, A_LSTAT = 5'h14, A_MSTAT = 5'h18, A_DIV = 5'h1C;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] b, input logic p, input logic f, input logic k);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; rx_parity_err = p; rx_frame_err = f; rx_break = k;
    @(negedge clk);
    rx_valid = 1'b0; rx_parity_err = 1'b0; rx_frame_err = 1'b0; rx_break = 1'b0;
  endtask

  task automatic txTake();
    @(negedge clk);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  function automatic logic [2:0] expId(input logic [3:0] ie, input bit err, input bit dr,
                                       input bit thre, input bit md);
    if (err && ie[2])       return 3'b110;
    else if (dr && ie[0])   return 3'b100;
    else if (thre && ie[1]) return 3'b010;
    else if (md && ie[3])   return 3'b000;
    else                    return 3'b001;
  endfunction

  task automatic cleanState();
    logic [31:0] d;
    busWrite(A_IEN, 32'h0);
    modem_status = 8'h00;
    busRead(A_LSTAT, d);
    busRead(A_DATA, d);
    if (tx_valid) txTake();
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 5.0);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // ---- R1 reset state ----
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    chk("R1 settings", {line_ctrl, modem_ctrl, baud_div}, 32'h0);
    busRead(A_DATA, d);  chk("R1 data", d, 32'h0);
    busRead(A_IEN, d);   chk("R1 ien", d, 32'h0);
    busRead(A_IID, d);   chk("R1 iid", d, 32'h1);
    busRead(A_LCTL, d);  chk("R1 lctl", d, 32'h0);
    busRead(A_MCTL, d);  chk("R1 mctl", d, 32'h0);
    busRead(A_LSTAT, d); chk("R1 lstat", d, 32'h60);
    busRead(A_MSTAT, d); chk("R1 mstat", d, 32'h0);
    busRead(A_DIV, d);   chk("R1 div", d, 32'h0);

    // ---- R2/R3 decode with low address bits set, write-only readback ----
    busWrite(A_LCTL | 5'h3, 32'hFFFF_FF5A);
    chk("R2 lctl lands", {24'b0, line_ctrl}, 32'h5A);
    chk("R2 others untouched", {modem_ctrl, baud_div}, 24'h0);
    busWrite(A_MCTL | 5'h1, 32'h0000_01C3);
    chk("R3 mctl low bits", {24'b0, modem_ctrl}, 32'hC3);
    busWrite(A_DIV | 5'h2, 32'hABCD_1234);
    chk("R3 div low bits", {16'b0, baud_div}, 32'h1234);
    chk("R2 lctl kept", {24'b0, line_ctrl}, 32'h5A);
    busRead(A_LCTL, d);  chk("R3 lctl reads zero", d, 32'h0);
    busRead(A_MCTL | 5'h3, d); chk("R3 mctl reads zero", d, 32'h0);
    busRead(A_DIV, d);   chk("R3 div reads zero", d, 32'h0);
    busWrite(A_IEN, 32'hF);
    busRead(A_IEN, d);   chk("R3 ien reads zero", d, 32'h0);
    busWrite(A_IEN, 32'h0);

    // ---- R12 modem status passthrough ----
    modem_status = 8'hA5;
    busRead(A_MSTAT | 5'h2, d); chk("R12 mstat", d, 32'hA5);
    modem_status = 8'h00;

    // ---- R4 read-only ignore writes ----
    busWrite(A_LSTAT, 32'hFFFF_FFFF);
    busWrite(A_IID, 32'hFFFF_FFFF);
    busWrite(A_MSTAT, 32'hFFFF_FFFF);
    busRead(A_LSTAT, d); chk("R4 lstat unchanged", d, 32'h60);
    busRead(A_IID, d);   chk("R4 iid unchanged", d, 32'h1);
    chk("R4 outputs unchanged", {line_ctrl, modem_ctrl, baud_div},
        {8'h5A, 8'hC3, 16'h1234});
    chk("R4 no tx", {31'b0, tx_valid}, 32'h0);

    // ---- R5 receive ----
    pushRx(8'h3C, 0, 0, 0);
    chk("R5 rx_ready low", {31'b0, rx_ready}, 32'h0);
    busRead(A_LSTAT, d); chk("R5 dr set", d, 32'h61);
    busRead(A_DATA, d);  chk("R5 data", d, 32'h3C);
    chk("R5 rx_ready back", {31'b0, rx_ready}, 32'h1);
    busRead(A_LSTAT, d); chk("R5 dr clear", d, 32'h60);

    // ---- R6 overrun ----
    pushRx(8'h11, 0, 0, 0);
    pushRx(8'h22, 0, 0, 0);
    busRead(A_LSTAT, d); chk("R6 overrun lstat", d, 32'h63);
    busRead(A_DATA, d);  chk("R6 newest byte", d, 32'h22);
    busRead(A_LSTAT, d); chk("R6 dr clear", d, 32'h60);

    // ---- R6 coincident data read and arrival ----
    pushRx(8'h44, 0, 0, 0);
    @(negedge clk);
    reg_addr = A_DATA; reg_rd = 1'b1; rx_valid = 1'b1; rx_byte = 8'h55;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; rx_valid = 1'b0;
    chk("R6 same-cycle read old byte", d, 32'h44);
    busRead(A_LSTAT, d); chk("R6 same-cycle arrival wins", d, 32'h63);
    busRead(A_DATA, d);  chk("R6 same-cycle new byte", d, 32'h55);

    // ---- R7 error flags ----
    pushRx(8'h01, 0, 1, 0);
    busRead(A_DATA, d);
    busRead(A_LSTAT, d); chk("R7 frame sticky", d, 32'h68);
    busRead(A_LSTAT, d); chk("R7 cleared by read", d, 32'h60);
    pushRx(8'h02, 1, 0, 1);
    busRead(A_DATA, d);
    busRead(A_LSTAT, d); chk("R7 parity+break", d, 32'h74);
    pushRx(8'h03, 0, 1, 0);
    busRead(A_DATA, d);
    @(negedge clk);
    reg_addr = A_LSTAT; reg_rd = 1'b1;
    rx_valid = 1'b1; rx_byte = 8'h04; rx_parity_err = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; rx_valid = 1'b0; rx_parity_err = 1'b0;
    chk("R7 same-cycle read returns old", d, 32'h68);
    busRead(A_LSTAT, d); chk("R7 same-cycle new flag survives", d, 32'h65);
    busRead(A_DATA, d);

    // ---- R8 transmit ----
    tx_idle = 1'b0;
    busWrite(A_DATA, 32'h0000_01A5);
    chk("R8 tx_valid", {31'b0, tx_valid}, 32'h1);
    chk("R8 tx_byte", {24'b0, tx_byte}, 32'hA5);
    busRead(A_LSTAT, d); chk("R8 busy lstat", d, 32'h00);
    txTake();
    chk("R8 taken", {31'b0, tx_valid}, 32'h0);
    busRead(A_LSTAT, d); chk("R8 thre only", d, 32'h20);
    tx_idle = 1'b1;
    @(negedge clk);
    busRead(A_LSTAT, d); chk("R8 temt after idle", d, 32'h60);

    // ---- R9/R10/R11 exhaustive priority sweep ----
    for (int combo = 0; combo < 16; combo++) begin
      for (int ie = 0; ie < 16; ie++) begin
        bit err, dr, thre, md;
        logic [2:0] e;
        err = combo[0]; dr = combo[1]; thre = combo[2]; md = combo[3];
        cleanState();
        if (err) begin
          pushRx(8'hE0, 1, 0, 0);
          busRead(A_DATA, d);
        end
        if (dr) pushRx(8'hD0, 0, 0, 0);
        if (!thre) busWrite(A_DATA, 32'h77);
        modem_status = md ? 8'hF5 : 8'hF0;
        busWrite(A_IEN, ie);
        e = expId(ie[3:0], err, dr, thre, md);
        chk($sformatf("R11 irq combo=%0d ie=%0d", combo, ie), {31'b0, irq},
            {31'b0, (e != 3'b001)});
        busRead(A_IID, d);
        chk($sformatf("R10 R9 iid combo=%0d ie=%0d", combo, ie), d, {29'b0, e});
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule